// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers reset requests from five sources and turns them into five reset lines. Those lines are an external system reset that drives both the hard and the soft reset pins, an external reset that drives only the soft pin, a reset for the clock module, an internal system reset for the peripheral group, and a general internal reset for everything else. The peripheral group is the memory controller, system protection, serial interface, interrupt controller and parallel I/O. A parameter marks each source as synchronous or asynchronous. Another parameter sets which lines each source drives.

An asynchronous request is treated as a catastrophic failure and reaches its lines in the same cycle. A synchronous request is parked until the current bus cycle ends. While it is parked, the block forces the bus-monitor timeout on, so that a stalled cycle is cut off and the reset can go ahead. A read-modify-write lock does not lengthen that wait. When a reset takes effect, any bus cycle in progress is told to terminate. The lines are stretched after the last request goes away and are then released together, with the release retimed through a two-flop chain. A sticky cause vector records which sources have fired. Software clears it with write-one-to-clear pulses.

Top module: `rst_seq_ctrl`

## Requirements
- R1: An asynchronous request (a `req_i` bit whose `SRC_SYNC` bit is 0) asserts every line mapped to that source combinationally, in the same cycle, with no clock edge needed.
- R2: A synchronous request seen at clock edge `a` while the bus is idle leaves all lines low through edge `a+2` and raises its mapped lines after edge `a+3`. While `bus_cyc_i` is high and neither `bus_ack_i` nor the timeout is present, the request stays parked and drives no line.
- R3: `rmw_lock_i` has no effect. A parked synchronous request is released at the first `bus_ack_i`, whether or not the lock is high.
- R4: `bmon_force_o` is high while any synchronous request is parked. The bus monitor counts the edges of a bus cycle. When a forced cycle has lasted `BMON_LIMIT-1` edges without `bus_ack_i`, it pulses `bmon_timeout_o` for one cycle, and that pulse releases the parked request.
- R5: `bus_term_o` is high in any cycle in which `bus_cyc_i` is high and a reset takes effect: an asynchronous request, the release of a parked request, or a timeout.
- R6: The bit index of `req_i` names the source: 0 power-on, 1 external hard, 2 watchdog, 3 software, 4 external soft. By default, sources 2, 3 and 4 are synchronous. Power-on and external hard drive all five lines. Watchdog and software drive every line except the clock reset. External soft drives only the general internal reset.
- R7: Once driven, the lines stay asserted until `HOLD_CYC+2` clock edges after the last edge at which any request was still active. They are then all released on the same edge.
- R8: `rst_hard_o` follows the external system line. `rst_soft_o` is high whenever either the external system line or the external-only line is asserted.
- R9: Bit `s` of `cause_o` (same bit order as `req_i`) is set at the edge at which source `s` takes effect, and it stays set. A 1 on `cause_clr_i[s]` clears it at the next edge. A new event on the same edge wins over the clear.
- R10: An asynchronous request that arrives while a synchronous request is parked asserts its lines at once, without waiting for the bus cycle to end.
- R11: While `rst_ni` is low, all reset lines, the monitor outputs, `bus_term_o` and `cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low initialisation of the controller's own state |
| req_i | input | 5 | Reset requests, one bit per source |
| bus_cyc_i | input | 1 | A bus cycle is in progress |
| bus_ack_i | input | 1 | Normal termination of the current bus cycle |
| rmw_lock_i | input | 1 | Read-modify-write lock (does not delay reset) |
| cause_clr_i | input | 5 | Write-one-to-clear pulses for the cause vector |
| rst_hard_o | output | 1 | External hard reset pin |
| rst_soft_o | output | 1 | External soft reset pin |
| rst_clk_o | output | 1 | Clock module reset |
| rst_isys_o | output | 1 | Internal system reset (peripheral group) |
| rst_igen_o | output | 1 | General internal reset |
| bmon_force_o | output | 1 | Bus-monitor forced enable |
| bmon_timeout_o | output | 1 | Forced-termination pulse from the bus monitor |
| bus_term_o | output | 1 | Terminate the bus cycle in progress |
| cause_o | output | 5 | Sticky reset-cause bits |

## Verification
The bench builds the block with `HOLD_CYC=16` and `BMON_LIMIT=8`, and keeps the default source classes and mapping. The short monitor limit lets a stalled cycle reach its timeout within a few cycles, so the exact edge of the timeout pulse and of the reset that follows can be checked. The 16-edge hold lets the bench pin the release to one exact edge before the next scenario starts.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int N_SRC       = 5;
  localparam int N_LINE      = 5;
  localparam int SYNC_STAGES = 2;

  // line indices
  localparam int LN_EXTSYS  = 0;
  localparam int LN_EXTSOFT = 1;
  localparam int LN_CLK     = 2;
  localparam int LN_ISYS    = 3;
  localparam int LN_IGEN    = 4;

  typedef logic [N_SRC-1:0]  src_vec_t;
  typedef logic [N_LINE-1:0] line_vec_t;
  typedef logic [N_SRC*N_LINE-1:0] src_map_t;

  // OR together the line masks of every active source
  function automatic line_vec_t map_lines(src_vec_t act, src_map_t map);
    line_vec_t r;
    r = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (act[s]) r = r | map[s*N_LINE +: N_LINE];
    end
    return r;
  endfunction

  // width of a counter that must hold values 0..n
  function automatic int cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rst_req_arbiter.sv
module rst_req_arbiter
  import rst_seq_pkg::*;
#(
  parameter src_vec_t SRC_SYNC = 5'b11100
) (
  input  logic     clk,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  logic     boundary_i,
  input  src_vec_t cause_clr_i,
  output src_vec_t fire_o,
  output src_vec_t live_o,
  output src_vec_t pend_o,
  output src_vec_t cause_o
);
  src_vec_t pend_q, on_q, cause_q;
  src_vec_t async_req, sync_req, fire;

  assign async_req = req_i & ~SRC_SYNC;
  assign sync_req  = req_i & SRC_SYNC;
  assign fire      = pend_q & {N_SRC{boundary_i}};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      on_q    <= '0;
      cause_q <= '0;
    end else begin
      pend_q  <= (pend_q & ~fire) | (sync_req & ~on_q & ~fire);
      on_q    <= (on_q | fire) & req_i;
      cause_q <= (cause_q & ~cause_clr_i) | async_req | fire;
    end
  end

  assign fire_o  = fire;
  assign live_o  = async_req | fire | (on_q & req_i);
  assign pend_o  = pend_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/rst_bus_monitor.sv
module rst_bus_monitor
  import rst_seq_pkg::*;
#(
  parameter int unsigned BMON_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bus_cyc_i,
  input  logic bus_ack_i,
  input  logic force_i,
  output logic timeout_o
);
  localparam int BW = cnt_width(BMON_LIMIT - 1);
  localparam logic [BW-1:0] LAST = BW'(BMON_LIMIT - 1);

  logic [BW-1:0] cnt_q;
  logic          expire;

  assign expire = force_i & bus_cyc_i & ~bus_ack_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!bus_cyc_i || bus_ack_i || expire) cnt_q <= '0;
    else if (cnt_q != LAST)                  cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_o = expire;
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  line_vec_t demand_i,
  output line_vec_t line_o
);
  localparam int CW = cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  line_vec_t     hold_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (|demand_i) begin
      cnt_q  <= RELOAD;
      hold_q <= hold_q | demand_i;
    end else if (cnt_q > CW'(1)) begin
      cnt_q  <= cnt_q - 1'b1;
    end else if (cnt_q == CW'(1)) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end
  end

  // release retimed per line through a short flop chain
  for (genvar i = 0; i < N_LINE; i++) begin : g_rel
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], hold_q[i]};
    end
    assign line_o[i] = sh_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter src_vec_t    SRC_SYNC   = 5'b11100,
  parameter src_map_t    SRC_MAP    = 25'b10000_11011_11011_11111_11111,
  parameter int unsigned HOLD_CYC   = 16,
  parameter int unsigned BMON_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [4:0] req_i,
  input  logic       bus_cyc_i,
  input  logic       bus_ack_i,
  input  logic       rmw_lock_i,
  input  logic [4:0] cause_clr_i,
  output logic       rst_hard_o,
  output logic       rst_soft_o,
  output logic       rst_clk_o,
  output logic       rst_isys_o,
  output logic       rst_igen_o,
  output logic       bmon_force_o,
  output logic       bmon_timeout_o,
  output logic       bus_term_o,
  output logic [4:0] cause_o
);
  src_vec_t  fire_w, live_w, pend_w;
  line_vec_t async_lines_w, demand_w, held_w, lines_w;
  logic      boundary_w, timeout_w, lock_ignored_w;

  assign boundary_w     = ~bus_cyc_i | bus_ack_i | timeout_w;
  assign lock_ignored_w = rmw_lock_i & bmon_force_o;

  rst_req_arbiter #(.SRC_SYNC(SRC_SYNC)) u_arb (
    .clk(clk), .rst_ni(rst_ni), .req_i(req_i), .boundary_i(boundary_w),
    .cause_clr_i(cause_clr_i), .fire_o(fire_w), .live_o(live_w),
    .pend_o(pend_w), .cause_o(cause_o)
  );

  rst_bus_monitor #(.BMON_LIMIT(BMON_LIMIT)) u_bmon (
    .clk(clk), .rst_ni(rst_ni), .bus_cyc_i(bus_cyc_i), .bus_ack_i(bus_ack_i),
    .force_i(bmon_force_o), .timeout_o(timeout_w)
  );

  assign async_lines_w = map_lines(req_i & ~SRC_SYNC, SRC_MAP);
  assign demand_w      = map_lines(live_w, SRC_MAP);

  rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_str (
    .clk(clk), .rst_ni(rst_ni), .demand_i(demand_w), .line_o(held_w)
  );

  assign lines_w = held_w | async_lines_w;

  assign rst_hard_o     = lines_w[LN_EXTSYS];
  assign rst_soft_o     = lines_w[LN_EXTSYS] | lines_w[LN_EXTSOFT];
  assign rst_clk_o      = lines_w[LN_CLK];
  assign rst_isys_o     = lines_w[LN_ISYS];
  assign rst_igen_o     = lines_w[LN_IGEN];
  assign bmon_force_o   = |pend_w;
  assign bmon_timeout_o = timeout_w;
  assign bus_term_o     = bus_cyc_i & ((|fire_w) | (|(req_i & ~SRC_SYNC)) | timeout_w);
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
  import rst_seq_pkg::*;
#(
  parameter src_vec_t SRC_SYNC = 5'b11100,
  parameter src_map_t SRC_MAP  = 25'b10000_11011_11011_11111_11111
) (
  input logic       clk,
  input logic       rst_ni,
  input logic [4:0] req_i,
  input logic       bus_cyc_i,
  input logic       bus_ack_i,
  input logic [4:0] cause_clr_i,
  input logic [4:0] cause_o,
  input logic       rst_hard_o,
  input logic       rst_soft_o,
  input logic       rst_clk_o,
  input logic       rst_isys_o,
  input logic       rst_igen_o,
  input logic       bmon_force_o,
  input logic       bmon_timeout_o,
  input logic       bus_term_o,
  input logic [4:0] fire_w,
  input logic       lock_ignored_w
);
  line_vec_t want, seen;
  assign want = map_lines(req_i & ~SRC_SYNC, SRC_MAP);
  assign seen = {rst_igen_o, rst_isys_o, rst_clk_o, rst_soft_o, rst_hard_o};

  assert_async_now_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (want != '0) |-> ((seen & want) == want));

  assert_lock_no_delay_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_ignored_w && bus_cyc_i && bus_ack_i) |-> bus_term_o);

  assert_timeout_forced_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    bmon_timeout_o |-> (bmon_force_o && bus_cyc_i && !bus_ack_i));

  assert_term_on_release_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_cyc_i && (fire_w != '0 || bmon_timeout_o)) |-> bus_term_o);

  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rst_igen_o) |-> (!rst_hard_o && !rst_clk_o && !rst_isys_o));

  assert_hard_implies_soft_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_hard_o |-> rst_soft_o);

  assert_cause_w1c_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cause_clr_i != '0 && fire_w == '0 && (req_i & ~SRC_SYNC) == '0)
      |=> ((cause_o & $past(cause_clr_i)) == '0));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.SRC_SYNC(SRC_SYNC), .SRC_MAP(SRC_MAP)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .req_i(req_i), .bus_cyc_i(bus_cyc_i),
  .bus_ack_i(bus_ack_i), .cause_clr_i(cause_clr_i), .cause_o(cause_o),
  .rst_hard_o(rst_hard_o), .rst_soft_o(rst_soft_o), .rst_clk_o(rst_clk_o),
  .rst_isys_o(rst_isys_o), .rst_igen_o(rst_igen_o), .bmon_force_o(bmon_force_o),
  .bmon_timeout_o(bmon_timeout_o), .bus_term_o(bus_term_o), .fire_w(fire_w),
  .lock_ignored_w(lock_ignored_w)
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] req_i = '0;
  logic       bus_cyc_i = 1'b0, bus_ack_i = 1'b0, rmw_lock_i = 1'b0;
  logic [4:0] cause_clr_i = '0;
  logic       rst_hard_o, rst_soft_o, rst_clk_o, rst_isys_o, rst_igen_o;
  logic       bmon_force_o, bmon_timeout_o, bus_term_o;
  logic [4:0] cause_o;

  always #10 clk = ~clk;  // 50 MHz

  rst_seq_ctrl #(.HOLD_CYC(16), .BMON_LIMIT(8)) u_rst_seq_ctrl (.*);

  // observed vector: cause[12:8] term[7] tmo[6] force[5] hard soft clk isys igen [4:0]
  logic [12:0] obs;
  assign obs = {cause_o, bus_term_o, bmon_timeout_o, bmon_force_o,
                rst_hard_o, rst_soft_o, rst_clk_o, rst_isys_o, rst_igen_o};

  localparam logic [12:0] MR = 13'h001F, MF = 13'h0020, MT = 13'h0040,
                          MB = 13'h0080, MC = 13'h1F00;

  typedef struct { int cyc; logic [12:0] m; logic [12:0] v; string tag; } item_t;
  item_t q[$];
  int cnt = 0, errors = 0, checks = 0;
  bit done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic expect_at(int k, logic [12:0] m, logic [12:0] v, string tag);
    item_t it;
    it.cyc = cnt + k; it.m = m; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations away from the clock edges
  always @(negedge clk) begin
    #5;
    while (q.size() > 0 && q[0].cyc <= cnt) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc != cnt || (obs & it.m) !== (it.v & it.m)) begin
        errors++;
        $display("FAIL %s: cycle %0d got %h expected %h (mask %h)",
                 it.tag, cnt, obs & it.m, it.v & it.m, it.m);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic clear_causes();
    cause_clr_i = 5'h1F;
    expect_at(1, MC, 13'h0000, "R9 cause cleared");
    step(1);
    cause_clr_i = '0;
    step(2);
  endtask

  initial begin
    step(3);
    expect_at(0, 13'h1FFF, 13'h0000, "R11 reset state");
    step(1);
    rst_ni = 1'b1;
    step(2);

    // async power-on: immediate, all lines, hold and release
    req_i = 5'b00001;
    expect_at(0, MR, 13'h001F, "R1 async immediate");
    expect_at(1, MC, 13'h0100, "R9 cause power-on set");
    step(4);
    req_i = '0;
    expect_at(17, MR, 13'h001F, "R7 still held");
    expect_at(18, MR, 13'h0000, "R7 released together");
    step(20);
    clear_causes();

    // sync watchdog on idle bus
    req_i = 5'b00100;
    expect_at(3, MR, 13'h0000, "R2 sync latency low");
    expect_at(4, MR, 13'h001B, "R6 watchdog map");
    step(5);
    req_i = '0;
    expect_at(18, MR | MC, 13'h0400, "R9 watchdog cause after release");
    step(20);
    clear_causes();

    // sync external soft: general internal reset only
    req_i = 5'b10000;
    expect_at(4, MR, 13'h0001, "R6 ext soft only general");
    step(5);
    req_i = '0;
    step(20);
    clear_causes();

    // software reset parked behind a locked bus cycle, released by ack
    bus_cyc_i = 1'b1; rmw_lock_i = 1'b1; req_i = 5'b01000;
    expect_at(1, MF, MF, "R4 force while parked");
    expect_at(4, MR | MB, 13'h0000, "R2 parked during cycle");
    step(5);
    bus_ack_i = 1'b1;
    expect_at(0, MR | MB, MB, "R5 term on release");
    step(1);
    bus_ack_i = 1'b0; bus_cyc_i = 1'b0; rmw_lock_i = 1'b0;
    expect_at(0, MF, 13'h0000, "R4 force drops");
    expect_at(1, MR, 13'h0000, "R3 chain latency");
    expect_at(2, MR, 13'h001B, "R3 lock ignored");
    step(3);
    req_i = '0;
    step(20);
    clear_causes();

    // stalled cycle: timeout ends it
    bus_cyc_i = 1'b1; req_i = 5'b00100;
    expect_at(6, MR | MT, 13'h0000, "R4 no early timeout");
    expect_at(7, MT | MB, MT | MB, "R4 timeout pulse");
    expect_at(9, MR, 13'h0000, "R4 chain latency");
    expect_at(10, MR, 13'h001B, "R4 reset proceeds");
    step(8);
    bus_cyc_i = 1'b0;
    step(3);
    req_i = '0;
    step(20);
    clear_causes();

    // async arrives while sync is parked
    bus_cyc_i = 1'b1; req_i = 5'b01000;
    step(2);
    req_i = 5'b01001;
    expect_at(0, MR | MB, 13'h001F | MB, "R10 async wins");
    step(2);
    req_i = '0; bus_cyc_i = 1'b0;
    step(25);
    expect_at(0, MR | MC, 13'h0900, "R9 both causes sticky");
    step(1);

    // clear races a new event: set wins
    req_i = 5'b00010; cause_clr_i = 5'b01011;
    expect_at(1, MC, 13'h0200, "R9 set wins over clear");
    step(1);
    req_i = '0; cause_clr_i = '0;
    step(22);
    expect_at(0, MR, 13'h0000, "R7 idle after hard reset");
    step(2);
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
    end
  end
endmodule